// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block decides which of four DMA channels gets the system bus next. Each channel has an asynchronous hardware request line, a mask bit and a software request bit. Hardware requests pass through a synchronizer and are then qualified by the mask. Software requests bypass the mask. When any qualified request is pending, the arbiter raises a hold request to the host. It grants nothing until the host returns hold acknowledge. At that point it latches the highest-priority pending channel and drives that channel's acknowledge line.

The grant stays with the latched channel until the peripheral signals the end of its service, even if a more urgent channel starts requesting in the meantime. Once service ends, the grant is withdrawn. Hold request stays up for one more clock and then falls, unless another request is still pending. In that case the arbiter goes back to waiting for acknowledge and grants again.

A small write port programs four settings: the mask vector, the software request vector, the request sense and the acknowledge sense. Only fixed priority is supported, with channel 0 the most urgent.

Top module: `dma_req_arbiter`

## Requirements
- R1: After reset, holdReq is 0 and every dackOut bit is 1, which is the inactive level for the default active-low acknowledge. All mask bits are set, so hardware requests are ignored.
- R2: An unmasked hardware request that is held at its active level raises holdReq on the third rising edge after it appears, because of the two synchronizer flops plus the state register.
- R3: A hardware request on a masked channel never raises holdReq.
- R4: A write with wrSel=1 loads the software request vector from wrData, one bit per channel. A set bit raises holdReq on the second edge, counting the edge that samples the write, whether or not that channel is masked.
- R5: No acknowledge is driven while holdAck is low. On the first edge that samples holdAck high with a request pending, the winning channel's dackOut goes active.
- R6: When several channels request at once, the lowest-numbered channel wins.
- R7: Once granted, a channel keeps its acknowledge until serviceDone is sampled high, even if a higher-priority request arrives.
- R8: On the edge that samples serviceDone, dackOut returns to the inactive level. holdReq falls on the following edge if nothing is pending. Otherwise it stays high and the next winner is granted once holdAck is seen.
- R9: A write with wrSel=2 sets the request sense from wrData[0]: 0 means active high, which is the reset value, and 1 means active low.
- R10: A write with wrSel=3 sets the acknowledge sense from wrData[0]: 0 means active low, which is the reset value, and 1 means active high. A granted channel's bit is driven to the active level and all other bits to the inactive level.
- R11: When service of a channel ends, that channel's software request bit is cleared.
- R12: If every request disappears before holdAck arrives, holdReq falls again without any grant.
- R13: A write with wrSel=0 loads the mask vector from wrData. A 1 in a bit masks that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select: 0 mask, 1 software request, 2 request sense, 3 acknowledge sense |
| wrData | input | 4 | Write data |
| dreqIn | input | 4 | Asynchronous hardware request lines |
| holdAck | input | 1 | Host has released the bus |
| serviceDone | input | 1 | Current channel's service has ended |
| holdReq | output | 1 | Bus hold request to the host |
| dackOut | output | 4 | Per-channel acknowledge, sense programmable |

## Verification
The bench measures the exact latency from a request to holdReq. A design that dropped or added a synchronizer stage would be off by one cycle. It holds holdAck low with requests pending and expects no acknowledge, which catches an arbiter that grants early.

It raises a more urgent request during a grant. A design that re-arbitrates every cycle would move the acknowledge. It ends service while another channel still waits and expects holdReq to stay high and a second grant to follow. A design that always dropped hold would stall there.

It flips both senses and requests through software on a masked channel. A design with the mask applied to software requests, or with a stale software bit, would either never request or would never let holdReq fall.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_GRANT,
    ST_DONE
  } arbState_t;

  typedef struct packed {
    logic latchWinner;
    logic grantOn;
    logic clearSoft;
  } arbStrobe_t;

  localparam logic [1:0] SEL_MASK    = 2'd0;
  localparam logic [1:0] SEL_SOFT    = 2'd1;
  localparam logic [1:0] SEL_REQSENS = 2'd2;
  localparam logic [1:0] SEL_ACKSENS = 2'd3;

endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int CH_W       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [NUM_CH-1:0] dreqIn,
  input  arbStrobe_t        strobe,
  output logic              anyPending,
  output logic [NUM_CH-1:0] dackOut
);

  logic [NUM_CH-1:0] syncQ [SYNC_STAGES];
  logic [NUM_CH-1:0] maskReg;
  logic [NUM_CH-1:0] softReq;
  logic              reqActLow;
  logic              ackActHigh;
  logic [CH_W-1:0]   winner;
  logic [CH_W-1:0]   topIdx;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] grantVec;

  genvar gs;
  generate
    for (gs = 0; gs < SYNC_STAGES; gs++) begin : g_sync
      if (gs == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) syncQ[gs] <= '0;
          else     syncQ[gs] <= dreqIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) syncQ[gs] <= '0;
          else     syncQ[gs] <= syncQ[gs-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      maskReg    <= '1;
      softReq    <= '0;
      reqActLow  <= 1'b0;
      ackActHigh <= 1'b0;
    end else begin
      if (wrEn) begin
        case (wrSel)
          SEL_MASK:    maskReg    <= wrData;
          SEL_SOFT:    softReq    <= wrData;
          SEL_REQSENS: reqActLow  <= wrData[0];
          default:     ackActHigh <= wrData[0];
        endcase
      end
      if (strobe.clearSoft) softReq[winner] <= 1'b0;
    end
  end

  always_comb begin
    pending = ((syncQ[SYNC_STAGES-1] ^ {NUM_CH{reqActLow}}) & ~maskReg) | softReq;
    anyPending = |pending;
  end

  always_comb begin
    topIdx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pending[i]) topIdx = CH_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     winner <= '0;
    else if (strobe.latchWinner) winner <= topIdx;
  end

  always_comb begin
    grantVec = '0;
    if (strobe.grantOn) grantVec[winner] = 1'b1;
    dackOut = ackActHigh ? grantVec : ~grantVec;
  end

endmodule

// File: rtl/dma_arb_control.sv
module dma_arb_control
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       anyPending,
  input  logic       holdAck,
  input  logic       serviceDone,
  output arbStrobe_t strobe,
  output logic       holdReq
);

  arbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: if (anyPending) stateNext = ST_WAIT;
      ST_WAIT: begin
        if (!anyPending) begin
          stateNext = ST_IDLE;
        end else if (holdAck) begin
          stateNext          = ST_GRANT;
          strobe.latchWinner = 1'b1;
        end
      end
      ST_GRANT: begin
        strobe.grantOn = 1'b1;
        if (serviceDone) begin
          stateNext        = ST_DONE;
          strobe.clearSoft = 1'b1;
        end
      end
      default: stateNext = anyPending ? ST_WAIT : ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  assign holdReq = (state != ST_IDLE);

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter #(
  parameter int NUM_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [NUM_CH-1:0] wrData,
  input  logic [NUM_CH-1:0] dreqIn,
  input  logic              holdAck,
  input  logic              serviceDone,
  output logic              holdReq,
  output logic [NUM_CH-1:0] dackOut
);

  dma_arb_pkg::arbStrobe_t strobe;
  logic anyPending;

  dma_arb_datapath #(.NUM_CH(NUM_CH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dreqIn(dreqIn), .strobe(strobe), .anyPending(anyPending), .dackOut(dackOut)
  );

  dma_arb_control u_ctl (
    .clk(clk), .rst(rst), .anyPending(anyPending), .holdAck(holdAck),
    .serviceDone(serviceDone), .strobe(strobe), .holdReq(holdReq)
  );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              holdAck,
  input logic              serviceDone,
  input logic              holdReq,
  input logic [NUM_CH-1:0] dackOut
);

  logic granted;
  assign granted = ($countones(dackOut) == 1) || ($countones(dackOut) == NUM_CH - 1);

  // R1: idle right after reset
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!holdReq && !granted));

  // R5: an acknowledge only exists under a held bus
  a_r5_grant_needs_hold: assert property (@(posedge clk) disable iff (rst)
    granted |-> holdReq);

  // R5: a new grant follows a sampled hold acknowledge
  a_r5_grant_after_ack: assert property (@(posedge clk) disable iff (rst)
    (granted && !$past(granted)) |-> $past(holdAck));

  // R7: grant stays put until service ends
  a_r7_grant_stable: assert property (@(posedge clk) disable iff (rst)
    ($past(granted) && !$past(serviceDone)) |-> $stable(dackOut));

  // R8: hold falls only when no grant was active the cycle before
  a_r8_hold_drop: assert property (@(posedge clk) disable iff (rst)
    $fell(holdReq) |-> !$past(granted));

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst(rst), .holdAck(holdAck), .serviceDone(serviceDone),
  .holdReq(holdReq), .dackOut(dackOut)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [3:0] wrData = '0;
  logic [3:0] dreqIn = '0;
  logic       holdAck = 1'b0;
  logic       serviceDone = 1'b0;
  logic       holdReq;
  logic [3:0] dackOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .dreqIn(dreqIn), .holdAck(holdAck), .serviceDone(serviceDone),
    .holdReq(holdReq), .dackOut(dackOut)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chkHold(string req, logic exp);
    total++;
    if (holdReq !== exp) begin
      bad++;
      $display("FAIL %s holdReq actual=%b expected=%b t=%0t", req, holdReq, exp, $time);
    end
  endtask

  task automatic chkDack(string req, logic [3:0] exp);
    total++;
    if (dackOut !== exp) begin
      bad++;
      $display("FAIL %s dackOut actual=%b expected=%b t=%0t", req, dackOut, exp, $time);
    end
  endtask

  task automatic regWrite(logic [1:0] sel, logic [3:0] data);
    wrEn = 1'b1; wrSel = sel; wrData = data;
    step(1);
    wrEn = 1'b0;
  endtask

  task automatic endService();
    serviceDone = 1'b1;
    step(1);
    serviceDone = 1'b0;
  endtask

  task automatic t_reset();
    chkHold("R1", 1'b0);
    chkDack("R1", 4'b1111);
    dreqIn = 4'b0001;
    step(6);
    chkHold("R3", 1'b0);
    dreqIn = 4'b0000;
    step(3);
  endtask

  task automatic t_hwGrant();
    regWrite(2'd0, 4'b0000); // R13 unmask all
    dreqIn = 4'b0100;
    step(2);
    chkHold("R2", 1'b0);
    step(1);
    chkHold("R2", 1'b1);
    step(3);
    chkDack("R5", 4'b1111);
    holdAck = 1'b1;
    step(1);
    chkDack("R5", 4'b1011);
    dreqIn = 4'b0000;
    step(3);
    endService();
    chkDack("R8", 4'b1111);
    chkHold("R8", 1'b1);
    step(1);
    chkHold("R8", 1'b0);
    holdAck = 1'b0;
    step(2);
  endtask

  task automatic t_priority();
    dreqIn = 4'b1010;
    step(3);
    holdAck = 1'b1;
    step(1);
    chkDack("R6", 4'b1101);
    dreqIn = 4'b1011;
    step(4);
    chkDack("R7", 4'b1101);
    dreqIn = 4'b1001;
    step(3);
    endService();
    chkDack("R8", 4'b1111);
    chkHold("R8", 1'b1);
    step(2);
    chkDack("R6", 4'b1110);
    dreqIn = 4'b0000;
    step(3);
    endService();
    step(1);
    chkHold("R8", 1'b0);
    holdAck = 1'b0;
    step(2);
  endtask

  task automatic t_soft();
    regWrite(2'd0, 4'b1111); // R13 mask all
    dreqIn = 4'b0010;
    step(4);
    chkHold("R13", 1'b0);
    dreqIn = 4'b0000;
    step(2);
    wrEn = 1'b1; wrSel = 2'd1; wrData = 4'b1000;
    step(1);
    wrEn = 1'b0;
    chkHold("R4", 1'b0);
    step(1);
    chkHold("R4", 1'b1);
    holdAck = 1'b1;
    step(1);
    chkDack("R4", 4'b0111);
    endService();
    step(1);
    chkHold("R11", 1'b0);
    step(3);
    chkHold("R11", 1'b0);
    holdAck = 1'b0;
  endtask

  task automatic t_withdraw();
    regWrite(2'd0, 4'b0000);
    dreqIn = 4'b0010;
    step(3);
    chkHold("R12", 1'b1);
    dreqIn = 4'b0000;
    step(3);
    chkHold("R12", 1'b0);
    chkDack("R12", 4'b1111);
    step(2);
  endtask

  task automatic t_sense();
    dreqIn = 4'b1111;
    step(3);
    chkHold("R9", 1'b1);
    dreqIn = 4'b0000;
    step(3);
    dreqIn = 4'b1111;
    step(2);
    regWrite(2'd2, 4'b0001);
    step(3);
    chkHold("R9", 1'b0);
    dreqIn = 4'b1011;
    step(3);
    chkHold("R9", 1'b1);
    regWrite(2'd3, 4'b0001);
    chkDack("R10", 4'b0000);
    holdAck = 1'b1;
    step(1);
    chkDack("R10", 4'b0100);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_hwGrant();
    t_priority();
    t_soft();
    t_withdraw();
    t_sense();
    step(2);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    summary();
  end

endmodule